// File: doc/BRIEF.md
# Writeback Frame Capture Controller

This block captures a single frame of pixel lines arriving on a line-oriented stream and stores it in memory as a raster image. Software programs a destination base address, a line pitch in bytes and the frame width and height through a small 32-bit register port. It then issues a start command. Each accepted pixel becomes one 32-bit word write. The word for pixel `c` of line `n` goes to `base + n*pitch + 4*c`. Pixels beyond the programmed width on a line are dropped.

The controller counts finished lines in a progress register. It reports busy while a frame is in flight and can raise an idle interrupt when the frame ends. Software acknowledges the interrupt by clearing its enable bit. An abort command ends the frame at once. A power-down bit keeps the controller from starting. A read-only signature sits in the top byte of the control register. An optional second frame-start pulse can be produced when the frame ends.

Register offsets are ptr 0x00, pitch 0x04, dims 0x08, ctrl 0x0C and progress 0x10. The dims register holds height in bits 31:16 and width in bits 15:0. The ctrl bits are:
- bit 0: start
- bit 1: busy, read-only
- bit 2: idle interrupt enable
- bit 14: abort
- bit 15: repeat the frame-start pulse at end of frame
- bit 21: power-down
- bits 23:22: read `01`
- bits 31:24: read `0x54`

Top module: `wbcap_top`

## Requirements
- R1: After reset the outputs are as follows.
  - ctrl reads 0x54400000.
  - progress reads 0.
  - `pix_ready`, `mem_we`, `irq` and `frame_start` are 0.
- R2: The ptr register reads back with bits 1:0 forced to 0. The pitch register reads back with bits 3:0 forced to 0. The dims register reads back exactly as written.
- R3: ctrl bits 31:24 always read 0x54 and bits 23:22 always read 01, whatever is written. Bit 0 and bit 14 always read 0.
- R4: A ctrl write with bit 0 set, while idle and not powered down, has these effects one cycle later:
  - busy (ctrl bit 1) and `pix_ready` are 1.
  - `frame_start` pulses for that one cycle.
- R5: A pixel accepted while busy, at column c < width of line n, produces a write in the next cycle. The write has `mem_we`=1, `mem_addr` = base + n*pitch + 4*c and `mem_wdata` = the pixel.
- R6: Pixels at column c >= width, and cycles with `pix_valid` low, produce no write.
- R7: Progress counts lines ended by `pix_last`. After the line that brings progress to height, busy and `pix_ready` drop in the next cycle.
- R8: When the frame ends with ctrl bit 2 set, `irq` goes high and stays high until software clears bit 2. With bit 2 clear, `irq` stays low.
- R9: A ctrl write with bit 14 set while busy clears busy in the next cycle. It suppresses any write for a pixel in that same cycle, and no later pixel is written.
- R10: A start command written while busy is ignored: progress keeps counting and no `frame_start` pulse occurs.
- R11: Progress resets to 0 on each accepted start.
- R12: With ctrl bit 15 set, `frame_start` pulses again in the cycle busy drops at the end of the frame. With bit 15 clear it does not.
- R13: While ctrl bit 21 is set, a start command is ignored. Bit 21 reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the addressed register |
| pix_valid | input | 1 | Pixel present on the stream |
| pix_data | input | 32 | Pixel value |
| pix_last | input | 1 | Marks the last pixel of a line |
| pix_ready | output | 1 | Stream accepts pixels (frame in flight) |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Byte address of the write |
| mem_wdata | output | 32 | Data of the write |
| frame_start | output | 1 | One-cycle frame-start pulse |
| irq | output | 1 | Idle interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data, and 16-bit dimension fields. With those widths, small random frames reach every address term. The frames are 1 to 6 pixels wide and 1 to 4 lines high, with random aligned bases and pitches. Ragged line lengths exercise the drop of pixels beyond the width. Directed cases cover the following:
- a start arriving mid-frame
- an abort in the same cycle as a pixel
- a start under power-down

// File: rtl/wbcap_pkg.sv
package wbcap_pkg;
  localparam logic [4:0] OFS_PTR   = 5'h00;
  localparam logic [4:0] OFS_PITCH = 5'h04;
  localparam logic [4:0] OFS_DIMS  = 5'h08;
  localparam logic [4:0] OFS_CTRL  = 5'h0C;
  localparam logic [4:0] OFS_PROG  = 5'h10;

  localparam int BIT_GO    = 0;
  localparam int BIT_BUSY  = 1;
  localparam int BIT_IEN   = 2;
  localparam int BIT_ABORT = 14;
  localparam int BIT_REFS  = 15;
  localparam int BIT_PDN   = 21;

  localparam logic [7:0] SIG_HI = 8'h54;
  localparam logic [1:0] SIG_LO = 2'b01;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] pitch;
    logic [15:0] width;
    logic [15:0] height;
    logic        ien;
    logic        refs;
    logic        pdn;
  } cap_cfg_t;
endpackage

// File: rtl/wbcap_regs.sv
module wbcap_regs
  import wbcap_pkg::*;
#(
  parameter int DIMW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [4:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            busy,
  input  logic [DIMW-1:0] progress,
  output cap_cfg_t        cfg,
  output logic            go_req,
  output logic            abort_req
);
  logic [29:0] ptr_q;
  logic [27:0] pitch_q;
  logic [31:0] dims_q;
  logic        ien_q, refs_q, pdn_q;
  logic        ctrl_wr;

  assign ctrl_wr   = reg_we && (reg_addr == OFS_CTRL);
  assign abort_req = ctrl_wr && reg_wdata[BIT_ABORT];
  assign go_req    = ctrl_wr && reg_wdata[BIT_GO] && !reg_wdata[BIT_ABORT] && !reg_wdata[BIT_PDN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      pitch_q <= '0;
      dims_q  <= '0;
      ien_q   <= 1'b0;
      refs_q  <= 1'b0;
      pdn_q   <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        OFS_PTR:   ptr_q   <= reg_wdata[31:2];
        OFS_PITCH: pitch_q <= reg_wdata[31:4];
        OFS_DIMS:  dims_q  <= reg_wdata;
        OFS_CTRL: begin
          ien_q  <= reg_wdata[BIT_IEN];
          refs_q <= reg_wdata[BIT_REFS];
          pdn_q  <= reg_wdata[BIT_PDN];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        OFS_PTR:   reg_rdata <= {ptr_q, 2'b00};
        OFS_PITCH: reg_rdata <= {pitch_q, 4'b0000};
        OFS_DIMS:  reg_rdata <= dims_q;
        OFS_CTRL: begin
          reg_rdata            <= '0;
          reg_rdata[31:24]     <= SIG_HI;
          reg_rdata[23:22]     <= SIG_LO;
          reg_rdata[BIT_PDN]   <= pdn_q;
          reg_rdata[BIT_REFS]  <= refs_q;
          reg_rdata[BIT_IEN]   <= ien_q;
          reg_rdata[BIT_BUSY]  <= busy;
        end
        OFS_PROG:  reg_rdata <= 32'(progress);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  always_comb begin
    cfg        = '0;
    cfg.base   = {ptr_q, 2'b00};
    cfg.pitch  = {pitch_q, 4'b0000};
    cfg.width  = dims_q[15:0];
    cfg.height = dims_q[31:16];
    cfg.ien    = ien_q;
    cfg.refs   = refs_q;
    cfg.pdn    = pdn_q;
  end
endmodule

// File: rtl/wbcap_engine.sv
module wbcap_engine
  import wbcap_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int DIMW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  cap_cfg_t        cfg,
  input  logic            go_req,
  input  logic            abort_req,
  input  logic            pix_valid,
  input  logic [DW-1:0]   pix_data,
  input  logic            pix_last,
  output logic            busy,
  output logic [DIMW-1:0] progress,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            frame_start,
  output logic            irq
);
  localparam int PADW = AW - DIMW - 2;

  logic [DIMW-1:0] col_q;
  logic [AW-1:0]   line_base_q;
  logic            ended_q;
  logic            accept;
  logic            in_width;
  logic            last_line;
  logic [AW-1:0]   col_ofs;

  assign accept    = busy && pix_valid && !abort_req;
  assign in_width  = col_q < cfg.width[DIMW-1:0];
  assign last_line = ({1'b0, progress} + 1'b1) >= {1'b0, cfg.height[DIMW-1:0]};
  assign col_ofs   = {{PADW{1'b0}}, col_q, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      progress    <= '0;
      col_q       <= '0;
      line_base_q <= '0;
      ended_q     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      frame_start <= 1'b0;
      irq         <= 1'b0;
    end else begin
      mem_we      <= 1'b0;
      frame_start <= 1'b0;
      irq         <= cfg.ien && ended_q && !busy;
      if (abort_req && busy) begin
        busy    <= 1'b0;
        ended_q <= 1'b1;
      end else if (go_req && !busy) begin
        busy        <= 1'b1;
        ended_q     <= 1'b0;
        progress    <= '0;
        col_q       <= '0;
        line_base_q <= cfg.base;
        frame_start <= 1'b1;
      end else if (accept) begin
        if (in_width) begin
          mem_we    <= 1'b1;
          mem_addr  <= line_base_q + col_ofs;
          mem_wdata <= pix_data;
        end
        if (pix_last) begin
          col_q       <= '0;
          progress    <= progress + 1'b1;
          line_base_q <= line_base_q + cfg.pitch;
          if (last_line) begin
            busy        <= 1'b0;
            ended_q     <= 1'b1;
            frame_start <= cfg.refs;
          end
        end else if (in_width) begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wbcap_top.sv
module wbcap_top
  import wbcap_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int DIMW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  input  logic          pix_last,
  output logic          pix_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          frame_start,
  output logic          irq
);
  cap_cfg_t        cfg;
  logic            go_req, abort_req, busy;
  logic [DIMW-1:0] progress;

  wbcap_regs #(.DIMW(DIMW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .progress(progress), .cfg(cfg), .go_req(go_req), .abort_req(abort_req)
  );

  wbcap_engine #(.AW(AW), .DW(DW), .DIMW(DIMW)) u_engine (
    .clk(clk), .rst(rst), .cfg(cfg), .go_req(go_req), .abort_req(abort_req),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_last(pix_last),
    .busy(busy), .progress(progress), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .frame_start(frame_start), .irq(irq)
  );

  assign pix_ready = busy;
endmodule

// File: rtl/wbcap_chk.sv
module wbcap_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_we,
  input logic [4:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          frame_start,
  input logic          irq
);
  // R5: every write lands on a word boundary
  p_word_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[1:0] == 2'b00));

  // R6: a write only follows a pixel offered while the stream was open
  p_write_from_pixel_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(pix_valid) && $past(pix_ready)));

  // R9: abort closes the stream and suppresses the write of that cycle
  p_abort_stops_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 5'h0C && reg_wdata[14]) |=> (!pix_ready && !mem_we));

  // R4: the stream opens only together with a frame-start pulse
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pix_ready) |-> frame_start);

  // R8: the idle interrupt never coincides with an open frame
  p_irq_idle_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> !pix_ready);

  // R13: a start under power-down leaves the stream closed
  p_pdn_blocks_r13: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 5'h0C && reg_wdata[21] && !pix_ready) |=> !pix_ready);
endmodule

bind wbcap_top wbcap_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .frame_start(frame_start), .irq(irq)
);

// File: tb/tb_wbcap_top.sv
module tb_wbcap_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        pix_valid;
  logic [31:0] pix_data;
  logic        pix_last;
  logic        pix_ready, mem_we, frame_start, irq;
  logic [31:0] mem_addr, mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wbcap_top dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_last(pix_last), .pix_ready(pix_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .frame_start(frame_start), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_exp(input bit pdn, input bit refs, input bit ien, input bit bsy);
    return 32'h5440_0000 | (32'(pdn) << 21) | (32'(refs) << 15) | (32'(ien) << 2) | (32'(bsy) << 1);
  endfunction

  function automatic logic [31:0] addr_exp(input logic [31:0] b, input logic [31:0] p, input int n, input int c);
    return b + 32'(n) * p + 32'(c) * 4;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // Sends one line starting at a negedge; checks each write one cycle later.
  task automatic send_line(input logic [31:0] b, input logic [31:0] p, input int n,
                           input int w, input int len, input bit final_line, input bit refs);
    for (int k = 0; k < len; k++) begin
      logic [31:0] d;
      if ($urandom_range(0, 3) == 0) begin
        pix_valid = 1'b0;
        @(negedge clk);
        check(mem_we == 1'b0, "R6 idle cycle", 32'(mem_we), 0);
      end
      d = $urandom;
      pix_valid = 1'b1; pix_data = d; pix_last = (k == len - 1);
      @(negedge clk);
      pix_valid = 1'b0; pix_last = 1'b0;
      if (k < w) begin
        check(mem_we == 1'b1, "R5 write strobe", 32'(mem_we), 1);
        check(mem_addr == addr_exp(b, p, n, k), "R5 address", mem_addr, addr_exp(b, p, n, k));
        check(mem_wdata == d, "R5 data", mem_wdata, d);
      end else begin
        check(mem_we == 1'b0, "R6 beyond width", 32'(mem_we), 0);
      end
      if (k == len - 1 && final_line) begin
        check(pix_ready == 1'b0, "R7 busy drops", 32'(pix_ready), 0);
        check(frame_start == refs, "R12 end pulse", 32'(frame_start), 32'(refs));
      end
    end
  endtask

  task automatic start_frame(input logic [31:0] b, input logic [31:0] p, input int w, input int h,
                             input bit ien, input bit refs);
    logic [31:0] r;
    wr(5'h00, b);
    wr(5'h04, p);
    wr(5'h08, {16'(h), 16'(w)});
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'h0C;
    reg_wdata = 32'h1 | (32'(ien) << 2) | (32'(refs) << 15);
    @(negedge clk);
    reg_we = 1'b0;
    check(frame_start == 1'b1, "R4 start pulse", 32'(frame_start), 1);
    check(pix_ready == 1'b1, "R4 ready", 32'(pix_ready), 1);
    rd(5'h0C, r);
    check(r == ctrl_exp(0, refs, ien, 1), "R4 go self-clears, busy set", r, ctrl_exp(0, refs, ien, 1));
    rd(5'h10, r);
    check(r == 0, "R11 progress reset", r, 0);
  endtask

  task automatic full_frame(input logic [31:0] b, input logic [31:0] p, input int w, input int h,
                            input bit ien, input bit refs);
    logic [31:0] r;
    start_frame(b, p, w, h, ien, refs);
    for (int n = 0; n < h; n++)
      send_line(b, p, n, w, w + $urandom_range(0, 2), n == h - 1, refs);
    rd(5'h10, r);
    check(r == 32'(h), "R7 progress", r, 32'(h));
    repeat (2) @(negedge clk);
    check(irq == ien, "R8 irq on idle", 32'(irq), 32'(ien));
    if (ien) begin
      wr(5'h0C, 32'h0);
      repeat (2) @(negedge clk);
      check(irq == 1'b0, "R8 irq ack", 32'(irq), 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    pix_valid = 1'b0; pix_data = '0; pix_last = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check({pix_ready, mem_we, irq, frame_start} == 4'b0, "R1 outputs", 32'({pix_ready, mem_we, irq, frame_start}), 0);
    rd(5'h0C, r);
    check(r == 32'h5440_0000, "R1 ctrl", r, 32'h5440_0000);
    rd(5'h10, r);
    check(r == 0, "R1 progress", r, 0);

    // R2 alignment masking
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, r);
    check(r == 32'hFFFF_FFFC, "R2 ptr", r, 32'hFFFF_FFFC);
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, r);
    check(r == 32'hFFFF_FFF0, "R2 pitch", r, 32'hFFFF_FFF0);
    wr(5'h08, 32'h1234_5678); rd(5'h08, r);
    check(r == 32'h1234_5678, "R2 dims", r, 32'h1234_5678);

    // R3 signature survives writes
    wr(5'h0C, 32'h00C0_0000 | 32'h4000); rd(5'h0C, r);
    check(r == 32'h5440_0000, "R3 signature", r, 32'h5440_0000);

    // Random frames: R5, R6, R7, R8, R12
    for (int t = 0; t < 12; t++) begin
      int w = $urandom_range(1, 6);
      int h = $urandom_range(1, 4);
      logic [31:0] p = 32'(16 * $urandom_range(1, 4)) + ((32'(w) * 4 + 15) & ~32'hF);
      logic [31:0] b = {$urandom_range(0, 32'h0FFF_FFFF), 2'b00} & 32'h3FFF_FFFC;
      full_frame(b, p, w, h, t[0], t[1]);
    end

    // R10 start while busy ignored, R11 reset on new start
    start_frame(32'h1000, 32'h40, 2, 3, 0, 0);
    send_line(32'h1000, 32'h40, 0, 2, 2, 0, 0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'h0C; reg_wdata = 32'h1;
    @(negedge clk);
    reg_we = 1'b0;
    check(frame_start == 1'b0, "R10 no pulse", 32'(frame_start), 0);
    rd(5'h10, r);
    check(r == 1, "R10 progress kept", r, 1);
    send_line(32'h1000, 32'h40, 1, 2, 2, 0, 0);
    send_line(32'h1000, 32'h40, 2, 2, 3, 1, 0);
    rd(5'h10, r);
    check(r == 3, "R7 progress after R10", r, 3);
    start_frame(32'h2000, 32'h20, 1, 1, 0, 0);

    // R9 abort coincident with a pixel
    send_line(32'h2000, 32'h20, 0, 1, 0, 0, 0);
    @(negedge clk);
    pix_valid = 1'b1; pix_data = 32'hDEAD_BEEF; pix_last = 1'b0;
    reg_we = 1'b1; reg_addr = 5'h0C; reg_wdata = 32'h4004;
    @(negedge clk);
    reg_we = 1'b0;
    check(mem_we == 1'b0, "R9 write suppressed", 32'(mem_we), 0);
    check(pix_ready == 1'b0, "R9 ready low", 32'(pix_ready), 0);
    @(negedge clk);
    check(mem_we == 1'b0, "R9 no later write", 32'(mem_we), 0);
    pix_valid = 1'b0;
    rd(5'h0C, r);
    check(r == ctrl_exp(0, 0, 1, 0), "R9 busy clear", r, ctrl_exp(0, 0, 1, 0));
    check(irq == 1'b1, "R8 irq after abort", 32'(irq), 1);
    wr(5'h0C, 32'h0);

    // R13 power-down blocks start
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'h0C; reg_wdata = 32'h0020_0001;
    @(negedge clk);
    reg_we = 1'b0;
    check(pix_ready == 1'b0, "R13 start ignored", 32'(pix_ready), 0);
    check(frame_start == 1'b0, "R13 no pulse", 32'(frame_start), 0);
    rd(5'h0C, r);
    check(r == ctrl_exp(1, 0, 0, 0), "R13 readback", r, ctrl_exp(1, 0, 0, 0));
    wr(5'h0C, 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule